// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is a per-core watchdog that counts down a programmable interval. Each time the interval runs out without a keep-alive, the watchdog steps one stage higher. The first expiry raises an interrupt, the second a non-maskable interrupt, and the third a chip-wide soft-reset request. A keep-alive strobe (the poke) restarts the interval and drops the block back to idle. A configuration write supplies a length field and a mode field. The mode field decides how far the escalation may climb, or switches the watchdog off.

Time is measured in two layers. A free-running prescaler produces one tick every 2^PRE_W clocks. The length field forms the upper bits of a decrementer whose LOW_W lower bits are loaded with zero. With the defaults (16-bit length, 8 low bits, 256-clock prescaler) one period lasts (L*256+1)*256 clocks. That is 256 clocks for L=0, and just under 2^32 clocks for the largest length. The current stage can be read back at all times. Bit 1 of that field marks the NMI stage, so software can tell a watchdog NMI apart from other NMI sources.

Top module: `wdog_escalate`

## Requirements
- R1: After reset the stage is 0 (idle), irqOut, nmiOut and resetReq are low, and the mode is 0, so the stage stays 0 however long the clock runs.
- R2: After a configuration write or poke at clock edge E0, the first expiry falls on edge E0+P, where P=(L*2^LOW_W+1)*2^PRE_W and L is the length field. With the defaults, L=0 gives P=256.
- R3: With no poke, each expiry raises the stage by exactly one. The stage encoding is 0 idle, 1 interrupt, 2 NMI, 3 reset, so after k edges the stage is floor(k/P), capped as in R4.
- R4: Mode 0 keeps the stage at 0. Mode 1 caps the stage at 1, mode 2 caps it at 2, and mode 3 allows all of stages 1 to 3.
- R5: irqOut is high when stage>=1, nmiOut is high when stage>=2, and resetReq is high when stage==3. All three are levels, and stageOut[1] equals nmiOut.
- R6: A poke in any stage other than 3 returns the stage to 0 at the next edge and restarts both the prescaler and the decrementer, so the next expiry comes P edges after the poke.
- R7: A configuration write in any stage other than 3 loads the new length and mode, returns the stage to 0, and restarts the countdown. A write of mode 0 disables the watchdog.
- R8: Once stage 3 is reached, the stage, resetReq and the stored configuration ignore pokes and configuration writes until rst_n is asserted.
- R9: When a configuration write and a poke arrive in the same cycle, the write takes effect: the new length sets the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Strobe that loads cfgLen and cfgMode |
| cfgLen | input | LEN_W | Expiration length (upper decrementer bits) |
| cfgMode | input | 2 | 0 off, 1 irq only, 2 irq+NMI, 3 irq+NMI+reset |
| poke | input | 1 | Keep-alive strobe |
| irqOut | output | 1 | Interrupt level (stage >= 1) |
| nmiOut | output | 1 | Non-maskable interrupt level (stage >= 2) |
| resetReq | output | 1 | Soft-reset request (stage 3, sticky) |
| stageOut | output | 2 | Current stage, bit 1 set in the NMI stage and above |

## Verification
The embedded assertions check on every cycle that the stage only climbs one step at a time or returns to idle, and that it never goes beyond the mode cap. They also check that a poke outside the reset stage clears the stage, that the reset request never drops before rst_n, that the outputs nest (reset implies NMI, NMI implies interrupt), and that the decrementer never holds more than the loaded length. The exact length of each period cannot be shown cycle by cycle from local state, and neither can the interaction of poke timing with the countdown. The bench covers both. It sweeps every length and mode of a reduced configuration and compares stage and outputs each cycle against floor(k/P) capped by the mode. It also runs pokes, reconfiguration at stage 2, simultaneous write and poke, and a default-size instance for the 256-clock minimum period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    STG_IDLE = 2'd0,
    STG_IRQ  = 2'd1,
    STG_NMI  = 2'd2,
    STG_RST  = 2'd3
  } stage_e;

  // strobes from the stage control to the countdown datapath
  typedef struct packed {
    logic restart;  // clear prescaler, reload decrementer
    logic capture;  // take a new length value
    logic run;      // advance prescaler and decrementer
  } dpCtrl_t;

endpackage

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtrl_t          ctrl,
  input  logic [LEN_W-1:0] cfgLen,
  output logic             expire
);
  localparam int CNT_W = LEN_W + LOW_W;

  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] cntQ;
  logic [LEN_W-1:0] lenQ;
  logic             tick;
  logic [LEN_W-1:0] loadLen;

  assign tick    = ctrl.run && (preQ == '1);
  assign expire  = tick && (cntQ == '0);
  assign loadLen = ctrl.capture ? cfgLen : lenQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preQ <= '0;
      cntQ <= '0;
      lenQ <= '0;
    end else begin
      if (ctrl.capture) lenQ <= cfgLen;
      if (ctrl.restart) begin
        preQ <= '0;
        cntQ <= {loadLen, {LOW_W{1'b0}}};
      end else if (ctrl.run) begin
        preQ <= preQ + 1'b1;
        if (tick) begin
          if (cntQ == '0) cntQ <= {lenQ, {LOW_W{1'b0}}};
          else            cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  // R2: the decrementer never holds more than the loaded length allows
  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cntQ <= {lenQ, {LOW_W{1'b0}}});

  // R6: a restart leaves the prescaler at zero on the next cycle
  assert_restart_prescaler_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.restart |=> (preQ == '0));

endmodule

// File: rtl/wdog_stage_ctrl.sv
module wdog_stage_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrite,
  input  logic [1:0] cfgMode,
  input  logic       poke,
  input  logic       expire,
  output dpCtrl_t    ctrl,
  output stage_e     stageQ
);
  logic [1:0] modeQ;
  logic       locked;

  assign locked       = (stageQ == STG_RST);
  assign ctrl.capture = cfgWrite && !locked;
  assign ctrl.restart = (cfgWrite || poke) && !locked;
  // counting stops once the mode cap is reached
  assign ctrl.run     = (modeQ != 2'd0) && (2'(stageQ) < modeQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ  <= 2'd0;
      stageQ <= STG_IDLE;
    end else begin
      if (ctrl.capture) modeQ <= cfgMode;
      if (ctrl.restart)  stageQ <= STG_IDLE;
      else if (expire)   stageQ <= stage_e'(2'(stageQ) + 2'd1);
    end
  end

  // R3: the stage only steps up by one or falls back to idle
  assert_stage_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stageQ != $past(stageQ)) |->
      (stageQ == STG_IDLE || 2'(stageQ) == 2'($past(stageQ) + 2'd1)));

  // R4: the stage never goes above the mode cap
  assert_mode_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    2'(stageQ) <= modeQ);

  // R6: a poke outside the reset stage clears the stage
  assert_poke_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (poke && !locked) |=> (stageQ == STG_IDLE));

  // R8: the reset stage holds until rst_n
  assert_reset_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (stageQ == STG_RST));

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrite,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic [1:0]       cfgMode,
  input  logic             poke,
  output logic             irqOut,
  output logic             nmiOut,
  output logic             resetReq,
  output logic [1:0]       stageOut
);
  dpCtrl_t ctrl;
  logic    expire;
  stage_e  stage;

  wdog_stage_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgWrite (cfgWrite),
    .cfgMode  (cfgMode),
    .poke     (poke),
    .expire   (expire),
    .ctrl     (ctrl),
    .stageQ   (stage)
  );

  wdog_countdown #(
    .LEN_W (LEN_W),
    .LOW_W (LOW_W),
    .PRE_W (PRE_W)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .cfgLen (cfgLen),
    .expire (expire)
  );

  assign stageOut = stage;
  assign irqOut   = (stage != STG_IDLE);
  assign nmiOut   = (stage == STG_NMI) || (stage == STG_RST);
  assign resetReq = (stage == STG_RST);

  // R5: escalation outputs nest
  assert_outputs_nest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resetReq |-> nmiOut) and (nmiOut |-> irqOut));

  // R1: no output is active straight after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!irqOut && !nmiOut && !resetReq));

endmodule

// File: tb/wdog_escalate_tb.sv
module wdog_escalate_tb;
  localparam int LEN_W = 3;
  localparam int LOW_W = 2;
  localparam int PRE_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrite = 1'b0;
  logic [LEN_W-1:0] cfgLen = '0;
  logic [1:0] cfgMode = 2'd0;
  logic poke = 1'b0;
  logic irqOut, nmiOut, resetReq;
  logic [1:0] stageOut;

  logic fWrite = 1'b0;
  logic [15:0] fLen = '0;
  logic [1:0] fMode = 2'd0;
  logic fIrq, fNmi, fRst;
  logic [1:0] fStage;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  wdog_escalate #(.LEN_W(LEN_W), .LOW_W(LOW_W), .PRE_W(PRE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgLen(cfgLen),
    .cfgMode(cfgMode), .poke(poke), .irqOut(irqOut), .nmiOut(nmiOut),
    .resetReq(resetReq), .stageOut(stageOut));

  wdog_escalate u_dutFull (
    .clk(clk), .rst_n(rst_n), .cfgWrite(fWrite), .cfgLen(fLen),
    .cfgMode(fMode), .poke(1'b0), .irqOut(fIrq), .nmiOut(fNmi),
    .resetReq(fRst), .stageOut(fStage));

  function automatic int period(int l);
    return (l * (1 << LOW_W) + 1) * (1 << PRE_W);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(int l, int m, bit withPoke);
    @(negedge clk);
    cfgLen = LEN_W'(l); cfgMode = 2'(m); cfgWrite = 1'b1; poke = withPoke;
    @(negedge clk);
    cfgWrite = 1'b0; poke = 1'b0;
  endtask

  task automatic do_poke();
    @(negedge clk); poke = 1'b1;
    @(negedge clk); poke = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // compare stage and outputs with floor(k/P) capped by mode for n edges
  task automatic trace(int l, int m, int n, string tag);
    int per = period(l);
    bit badS = 0, badO = 0;
    int aS = 0, eS0 = 0, aO = 0, eO = 0;
    for (int k = 1; k <= n; k++) begin
      int e;
      int eo;
      @(negedge clk);
      e = k / per;
      if (e > m) e = m;
      eo = ((e == 3) ? 4 : 0) + ((e >= 2) ? 2 : 0) + ((e >= 1) ? 1 : 0)
         + ((stageOut[1] == nmiOut) ? 0 : 8);
      if (!badS && int'(stageOut) != e) begin badS = 1; aS = stageOut; eS0 = e; end
      if (!badO && int'({resetReq, nmiOut, irqOut}) != eo) begin
        badO = 1; aO = {resetReq, nmiOut, irqOut}; eO = eo;
      end
    end
    check(!badS, {tag, " stage trace"}, aS, eS0);
    check(!badO, "R5 output levels", aO, eO);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(stageOut == 2'd0 && !irqOut && !nmiOut && !resetReq, "R1 reset state",
          {resetReq, nmiOut, irqOut, stageOut}, 0);
    repeat (300) @(negedge clk);
    check(stageOut == 2'd0 && !irqOut, "R1 idle with mode 0", stageOut, 0);

    // R2: default-size instance, L=0 expires 256 edges after the write
    @(negedge clk); fLen = 16'd0; fMode = 2'd1; fWrite = 1'b1;
    @(negedge clk); fWrite = 1'b0;
    repeat (255) @(negedge clk);
    check(!fIrq, "R2 default L=0 before 256", fIrq, 0);
    @(negedge clk);
    check(fIrq && fStage == 2'd1, "R2 default L=0 at 256", fStage, 1);

    // R2 R3 R4: sweep all lengths and modes
    for (int l = 0; l < (1 << LEN_W); l++) begin
      for (int m = 0; m < 4; m++) begin
        do_reset();
        write_cfg(l, m, 0);
        trace(l, m, 3 * period(l) + 6, (m == 0) ? "R4" : ((l & 1) ? "R3" : "R2"));
        if (m == 3) begin
          // R8: pokes and writes are ignored in the reset stage
          do_poke();
          write_cfg(0, 1, 0);
          repeat (2) @(negedge clk);
          check(resetReq && stageOut == 2'd3, "R8 sticky reset", stageOut, 3);
          do_reset();
          check(!resetReq && stageOut == 2'd0, "R8 cleared by rst_n", stageOut, 0);
        end
      end
    end

    // R6: poke at stage 1 restarts the full period
    do_reset();
    write_cfg(2, 3, 0);
    repeat (period(2) + 5) @(negedge clk);
    check(stageOut == 2'd1, "R6 reached stage 1", stageOut, 1);
    do_poke();
    check(stageOut == 2'd0 && !irqOut, "R6 poke clears", stageOut, 0);
    repeat (period(2) - 1) @(negedge clk);
    check(stageOut == 2'd0, "R6 no expiry before P", stageOut, 0);
    @(negedge clk);
    check(stageOut == 2'd1, "R6 expiry at P after poke", stageOut, 1);

    // R7: reconfigure at stage 2 with a new length
    repeat (period(2)) @(negedge clk);
    check(stageOut == 2'd2 && stageOut[1] == nmiOut, "R7 reached NMI stage", stageOut, 2);
    write_cfg(5, 2, 0);
    check(stageOut == 2'd0, "R7 write clears stage", stageOut, 0);
    trace(5, 2, 3 * period(5), "R7");

    // R7: mode 0 disables
    write_cfg(1, 0, 0);
    repeat (5 * period(1)) @(negedge clk);
    check(stageOut == 2'd0 && !irqOut, "R7 mode 0 disables", stageOut, 0);

    // R9: write and poke together, new length wins
    write_cfg(1, 3, 0);
    repeat (period(1) + 2) @(negedge clk);
    write_cfg(6, 3, 1);
    check(stageOut == 2'd0, "R9 simultaneous clears", stageOut, 0);
    trace(6, 3, 3 * period(6) + 4, "R9");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule